// File: doc/BRIEF.md
# Clock-Control Configuration Register Bank

This block is the software-visible register bank of a clock control unit. It holds a set of 32-bit configuration words for the chip's PLLs, bus clock dividers, DRAM clocking and PLL tuning. A host reaches it over a simple single-cycle word-access bus with a request, a write flag, a byte address and write data. The block generates no clocks. It keeps the values that software writes and applies two write side effects. A PLL control word written with its enable bit set is stored with its lock bit set, so lock appears at once with no settle time. The update bit of the DRAM configuration word always reads back as zero after a write.

Every PLL control word has a lock flag that the block drives out as a vector. Other clock logic can use this vector as a PLL-ready indication. Offsets at or above the end of the implemented range, and byte addresses that are not word aligned, are outside the implemented space. Reads from that space return zero. Writes to it are dropped and raise an error strobe. Words inside the range that have no defined function can still be written and read back, and a write to one of them raises an unimplemented-access strobe.

Top module: `ccu_regfile`

## Requirements
- R1: After a synchronous active-low reset the words reset as follows, each at the byte offset given.
  - PLL control words: 0x000 and 0x020 = 0x00001000; 0x008 = 0x00035514; 0x010, 0x018, 0x038 and 0x048 = 0x03006207; 0x028 and 0x044 = 0x00041811.
  - Bus and memory words: 0x050 = 0x00010000; 0x054 = 0x00001010; 0x058 = 0x01000000; 0x0F4 = 0; 0x0FC = 0x80000000.
  - Stable-time words: 0x200 and 0x204 = 0x000000FF.
  - Bias words: 0x220 = 0x08100200; 0x224, 0x228, 0x22C, 0x23C and 0x248 = 0x10100000; 0x230 = 0x81104000; 0x234 and 0x244 = 0x10100010.
  - Tuning words: 0x250 = 0x0A101000; 0x260 = 0x14880000.
  - Every other implemented word resets to zero.
- R2: A write to any PLL control word (0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x038, 0x044, 0x048) whose data bit 31 is 1 stores the data with bit 28 forced to 1.
- R3: A write to a PLL control word whose data bit 31 is 0 stores all bits exactly as written, bit 28 included.
- R4: A write to the DRAM configuration word at 0x0F4 stores the data with bit 16 forced to 0.
- R5: A write to any other defined word stores the data unchanged.
- R6: An access is outside the implemented space when its byte address is 0x308 or above, or when address bits [1:0] are not zero. A read of such an access returns zero. A write of such an access changes no word and raises err_stb for exactly the one cycle after the write.
- R7: A write to an implemented but undefined word (for example 0x004 or 0x304) is stored unchanged and raises unimp_stb for exactly the one cycle after the write. Writes to defined words do not raise it.
- R8: Read data appears on rdata with rvalid high in the cycle after the read request. rvalid is low after write requests and after idle cycles.
- R9: Bit k of pll_locked equals bit 28 of the k-th PLL control word, counted in ascending offset order (bit 0 = 0x000, bit 8 = 0x048). It follows a write on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (10) | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | rdata holds the result of the previous cycle's read |
| err_stb | output | 1 | One-cycle strobe: write outside the implemented space |
| unimp_stb | output | 1 | One-cycle strobe: write to an undefined implemented word |
| pll_locked | output | 9 | Lock flag of each PLL control word |

## Verification
The block has three result timings relative to the clock edge that takes a request. Read data, rvalid and the two strobes are registered, so they are due in the cycle after that edge. A stored word, together with its pll_locked bit, changes at the edge itself. The bench drives each request half a cycle before an edge and samples one time unit after that edge. At that point the write's strobes and the read's data are both settled, and the next request has not yet been driven. Every write in the vector table is followed by a read-back at the same offset. This read-back exposes the stored value, including any bits the block forced, one cycle after the read request.

// File: rtl/ccu_regfile_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the register bank layout.
// Assumes 32-bit words and word indices equal to byte offset / 4.
package ccu_regfile_pkg;
    localparam int DATA_W   = 32;
    localparam int NPLL     = 9;
    localparam int EN_BIT   = 31;
    localparam int LOCK_BIT = 28;
    localparam int UPD_BIT  = 16;
    localparam int DRAM_IDX = 'h0F4 / 4;

    // Word index of the k-th PLL control word, ascending offset order.
    function automatic int pll_word(input int k);
        case (k)
            0: return 'h000 / 4;
            1: return 'h008 / 4;
            2: return 'h010 / 4;
            3: return 'h018 / 4;
            4: return 'h020 / 4;
            5: return 'h028 / 4;
            6: return 'h038 / 4;
            7: return 'h044 / 4;
            default: return 'h048 / 4;
        endcase
    endfunction

    // Reset value of a word index; undefined words reset to zero.
    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        case (idx * 4)
            'h000, 'h020:                      return 32'h0000_1000;
            'h008:                             return 32'h0003_5514;
            'h010, 'h018, 'h038, 'h048:        return 32'h0300_6207;
            'h028, 'h044:                      return 32'h0004_1811;
            'h050:                             return 32'h0001_0000;
            'h054:                             return 32'h0000_1010;
            'h058:                             return 32'h0100_0000;
            'h0FC:                             return 32'h8000_0000;
            'h200, 'h204:                      return 32'h0000_00FF;
            'h220:                             return 32'h0810_0200;
            'h224, 'h228, 'h22C, 'h23C, 'h248: return 32'h1010_0000;
            'h230:                             return 32'h8110_4000;
            'h234, 'h244:                      return 32'h1010_0010;
            'h250:                             return 32'h0A10_1000;
            'h260:                             return 32'h1488_0000;
            default:                           return '0;
        endcase
    endfunction

    // True when a word index has a defined function.
    function automatic bit is_defined(input int idx);
        case (idx * 4)
            'h000, 'h008, 'h010, 'h018, 'h020, 'h028, 'h038, 'h044, 'h048,
            'h050, 'h054, 'h058, 'h0F4, 'h0FC, 'h200, 'h204,
            'h220, 'h224, 'h228, 'h22C, 'h230, 'h234, 'h23C, 'h244, 'h248,
            'h250, 'h260: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ccu_decode.sv
`timescale 1ns/1ps
// Module: ccu_decode
// Classifies a byte address: in implemented space, word index, PLL word,
// DRAM configuration word, defined word. Purely combinational.
// Assumes LIMIT is a multiple of 4 and no larger than 2**ADDR_W.
module ccu_decode
    import ccu_regfile_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LIMIT  = 'h308,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx,
    output logic              is_pll,
    output logic              is_dram,
    output logic              is_def
);
    // Split the address and flag misaligned or high offsets.
    always_comb begin
        idx      = addr[ADDR_W-1:2];
        in_range = (addr[1:0] == 2'b00) && (int'(addr) < LIMIT);
    end

    // Match the word index against the PLL list and the defined-word set.
    always_comb begin
        is_pll = 1'b0;
        for (int k = 0; k < NPLL; k++) begin
            if (int'(idx) == pll_word(k)) is_pll = 1'b1;
        end
        is_dram = (int'(idx) == DRAM_IDX);
        is_def  = is_defined(int'(idx));
    end
endmodule

// File: rtl/ccu_wshape.sv
`timescale 1ns/1ps
// Module: ccu_wshape
// Applies write side effects: lock follows enable on PLL words, update bit
// clears on the DRAM configuration word. Combinational.
// Assumes is_pll and is_dram are never both set.
module ccu_wshape
    import ccu_regfile_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  logic              is_pll,
    input  logic              is_dram,
    output logic [DATA_W-1:0] wshaped
);
    // Force or clear the side-effect bits of the written value.
    always_comb begin
        wshaped = wdata;
        if (is_pll && wdata[EN_BIT]) wshaped[LOCK_BIT] = 1'b1;
        if (is_dram)                 wshaped[UPD_BIT]  = 1'b0;
    end
endmodule

// File: rtl/ccu_store.sv
`timescale 1ns/1ps
// Module: ccu_store
// Storage for every implemented word, each with its own reset constant.
// Gives a combinational read word and the PLL lock bits.
// Assumes idx addresses implemented words only when wr_en is high.
module ccu_store
    import ccu_regfile_pkg::*;
#(
    parameter int NWORDS = 194,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] rd_word,
    output logic [NPLL-1:0]   lock_bits
);
    logic [DATA_W-1:0] words [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        localparam logic [DATA_W-1:0] RST_VAL = reset_word(i);
        // Hold one word: reset constant or written value.
        always_ff @(posedge clk) begin
            if (!rst_n)                             words[i] <= RST_VAL;
            else if (wr_en && int'(idx) == i)       words[i] <= wval;
        end
    end

    // Select the addressed word for reading.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (int'(idx) == i) rd_word = words[i];
        end
    end

    for (genvar k = 0; k < NPLL; k++) begin : g_lock
        // Expose the lock bit of the k-th PLL word.
        assign lock_bits[k] = words[pll_word(k)][LOCK_BIT];
    end
endmodule

// File: rtl/ccu_regfile.sv
`timescale 1ns/1ps
// Module: ccu_regfile
// Clock-control register bank with registered reads, write side effects,
// error and unimplemented strobes and a per-PLL lock vector.
// Assumes one access per request cycle and synchronous active-low reset.
module ccu_regfile
    import ccu_regfile_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LIMIT  = 'h308
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              err_stb,
    output logic              unimp_stb,
    output logic [NPLL-1:0]   pll_locked
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NWORDS = LIMIT / 4;

    logic              in_range, is_pll, is_dram, is_def, wr_en;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wshaped, rd_word;

    ccu_decode #(.ADDR_W(ADDR_W), .LIMIT(LIMIT)) decode_i (
        .addr(addr), .in_range(in_range), .idx(idx),
        .is_pll(is_pll), .is_dram(is_dram), .is_def(is_def)
    );

    ccu_wshape wshape_i (
        .wdata(wdata), .is_pll(is_pll), .is_dram(is_dram), .wshaped(wshaped)
    );

    // Accept only writes that land in implemented space.
    assign wr_en = req && we && in_range;

    ccu_store #(.NWORDS(NWORDS), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wval(wshaped),
        .rd_word(rd_word), .lock_bits(pll_locked)
    );

    // Register read data, read valid and the access strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rvalid    <= 1'b0;
            err_stb   <= 1'b0;
            unimp_stb <= 1'b0;
        end else begin
            rvalid    <= req && !we;
            err_stb   <= req && we && !in_range;
            unimp_stb <= req && we && in_range && !is_def;
            if (req && !we) rdata <= in_range ? rd_word : '0;
        end
    end
endmodule

// File: rtl/ccu_regfile_chk.sv
`timescale 1ns/1ps
// Module: ccu_regfile_chk
// Port-level properties of ccu_regfile, attached by bind.
module ccu_regfile_chk
    import ccu_regfile_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LIMIT  = 'h308
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              err_stb,
    input logic              unimp_stb,
    input logic [NPLL-1:0]   pll_locked
);
    logic oob;
    assign oob = (addr[1:0] != 2'b00) || (int'(addr) >= LIMIT);

    a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);
    a_r8_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);
    a_r6_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && oob) |=> (rdata == '0));
    a_r6_err_on_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && oob) |=> err_stb);
    a_r6_err_only_for_oob: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && oob) |=> !err_stb);
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_stb && unimp_stb));
    a_r2_lock_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == '0 && wdata[EN_BIT]) |=> pll_locked[0]);
    a_r3_lock_as_written: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == '0 && !wdata[EN_BIT]) |=> (pll_locked[0] == $past(wdata[LOCK_BIT])));
    a_r9_lock_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we) |=> $stable(pll_locked));
endmodule

bind ccu_regfile ccu_regfile_chk #(.ADDR_W(ADDR_W), .LIMIT(LIMIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .err_stb(err_stb), .unimp_stb(unimp_stb),
    .pll_locked(pll_locked)
);

// File: tb/ccu_regfile_tb.sv
`timescale 1ns/1ps
module ccu_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, err_stb, unimp_stb;
    logic [8:0]  pll_locked;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    ccu_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err_stb(err_stb),
        .unimp_stb(unimp_stb), .pll_locked(pll_locked)
    );

    // {addr[9:0], wdata, expected readback, expected err, expected unimp}
    localparam int NV = 15;
    localparam logic [75:0] VEC [NV] = '{
        {10'h000, 32'h8000_0000, 32'h9000_0000, 1'b0, 1'b0},  // R2
        {10'h008, 32'h8012_3456, 32'h9012_3456, 1'b0, 1'b0},  // R2
        {10'h048, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},  // R3
        {10'h010, 32'h1000_0001, 32'h1000_0001, 1'b0, 1'b0},  // R3
        {10'h0F4, 32'hFFFF_FFFF, 32'hFFFE_FFFF, 1'b0, 1'b0},  // R4
        {10'h0F4, 32'h0001_0000, 32'h0000_0000, 1'b0, 1'b0},  // R4
        {10'h050, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0},  // R5
        {10'h230, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0},  // R5
        {10'h0FC, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},  // R5
        {10'h004, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0, 1'b1},  // R7
        {10'h304, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b0, 1'b1},  // R7
        {10'h308, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0},  // R6
        {10'h3FC, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0},  // R6
        {10'h044, 32'h8000_0000, 32'h9000_0000, 1'b0, 1'b0},  // R2
        {10'h018, 32'h9000_0000, 32'h9000_0000, 1'b0, 1'b0}   // R2 lock already set
    };

    // {addr[9:0], reset value}
    localparam int NR = 28;
    localparam logic [41:0] RST [NR] = '{
        {10'h260, 32'h1488_0000}, {10'h250, 32'h0A10_1000}, {10'h248, 32'h1010_0000},
        {10'h244, 32'h1010_0010}, {10'h23C, 32'h1010_0000}, {10'h234, 32'h1010_0010},
        {10'h230, 32'h8110_4000}, {10'h22C, 32'h1010_0000}, {10'h228, 32'h1010_0000},
        {10'h224, 32'h1010_0000}, {10'h220, 32'h0810_0200}, {10'h204, 32'h0000_00FF},
        {10'h200, 32'h0000_00FF}, {10'h0FC, 32'h8000_0000}, {10'h0F4, 32'h0000_0000},
        {10'h058, 32'h0100_0000}, {10'h054, 32'h0000_1010}, {10'h050, 32'h0001_0000},
        {10'h048, 32'h0300_6207}, {10'h044, 32'h0004_1811}, {10'h038, 32'h0300_6207},
        {10'h028, 32'h0004_1811}, {10'h020, 32'h0000_1000}, {10'h018, 32'h0300_6207},
        {10'h010, 32'h0300_6207}, {10'h008, 32'h0003_5514}, {10'h000, 32'h0000_1000},
        {10'h00C, 32'h0000_0000}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Write request; returns the strobes sampled after the taking edge.
    task automatic do_write(input logic [9:0] a, input logic [31:0] d,
                            output logic e, output logic u, output logic v);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        e = err_stb; u = unimp_stb; v = rvalid;
        req = 1'b0; we = 1'b0;
    endtask

    // Read request; returns data and valid sampled after the taking edge.
    task automatic do_read(input logic [9:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk); #1;
        d = rdata; v = rvalid;
        req = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic e, u, v;
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 R9: reset state of the outputs
        check({23'b0, pll_locked}, 32'h0, "R9 pll_locked after reset");
        check({29'b0, rvalid, err_stb, unimp_stb}, 32'h0, "R8 R6 R7 outputs idle after reset");

        // Vector walk: write, check strobes, read back.
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][75:66], VEC[i][65:34], e, u, v);
            check({31'b0, e}, {31'b0, VEC[i][1]}, $sformatf("R6 err_stb vector %0d", i));
            check({31'b0, u}, {31'b0, VEC[i][0]}, $sformatf("R7 unimp_stb vector %0d", i));
            check({31'b0, v}, 32'h0, $sformatf("R8 rvalid low after write %0d", i));
            do_read(VEC[i][75:66], d, v);
            check(d, VEC[i][33:2], $sformatf("R2-5 readback vector %0d (R2 R3 R4 R5 R6 R7)", i));
            check({31'b0, v}, 32'h1, $sformatf("R8 rvalid after read %0d", i));
        end

        // R6: strobe lasts one cycle
        do_write(10'h308, 32'h1, e, u, v);
        @(posedge clk); #1;
        check({31'b0, err_stb}, 32'h0, "R6 err_stb one cycle only");
        check({31'b0, rvalid}, 32'h0, "R8 rvalid low on idle");

        // R6: misaligned write dropped, neighbour word untouched
        do_write(10'h052, 32'h0, e, u, v);
        check({31'b0, e}, 32'h1, "R6 misaligned write err");
        do_read(10'h050, d, v);
        check(d, 32'hDEAD_BEEF, "R6 misaligned write ignored");
        do_read(10'h051, d, v);
        check(d, 32'h0, "R6 misaligned read zero");

        // R9: lock vector after table (words k=0,1,2,3,7 have bit 28 set)
        check({23'b0, pll_locked}, 32'h0000_008F, "R9 pll_locked pattern");
        do_write(10'h020, 32'h8000_0000, e, u, v);
        check({23'b0, pll_locked}, 32'h0000_009F, "R9 lock follows write next edge");
        do_write(10'h000, 32'h0000_0000, e, u, v);
        check({23'b0, pll_locked}, 32'h0000_009E, "R3 R9 lock cleared by write");

        // R1: reset again and read every default
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check({23'b0, pll_locked}, 32'h0, "R1 R9 lock cleared by reset");
        for (int i = 0; i < NR; i++) begin
            do_read(RST[i][41:32], d, v);
            check(d, RST[i][31:0], $sformatf("R1 default at 0x%03h", RST[i][41:32]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule